// File: doc/BRIEF.md
# Receive Destination Address Filter

This block watches the byte stream of an incoming Ethernet frame, collects the six destination address bytes and decides whether the frame is wanted. It compares the address against a programmed station address. It recognises the all-ones broadcast address and group addresses. It also looks up group addresses in a 64-entry hash table indexed by a CRC-32 of the address. A two-bit policy field selects one of four acceptance rules: station only, station plus broadcast plus hashed multicast, station plus broadcast plus every multicast, or everything.

The per-frame match flags are held until the next frame starts. When the MAC signals the end of a frame, they are merged with the MAC's error flags and the received length into a 64-bit receive status word. A single aggregate error bit accompanies that word. The raw table bit selected by the hash is also latched into a visible status output, but only while receive DMA is enabled.

Top module: `rxf_daddr_filter`

## Requirements
- R1: After reset every output is zero.
- R2: A byte is taken when `rx_byte_valid` is high. `rx_frame_start` marks the first byte of a frame. The k-th byte taken (k = 0..5) is compared with `own_addr[8k+7:8k]`. `dec_valid` pulses for exactly one cycle, in the cycle after the sixth byte is taken. Further bytes are ignored until the next frame start, and bytes seen before any frame start are ignored.
- R3: `dec_bcast` is set when all 48 address bits are one. `dec_mcast` is set when bit 0 of the first byte is one and the address is not broadcast.
- R4: `dec_own_hit` is set when all six address bytes equal the station address.
- R5: The hash index is bits 31:26 of a CRC register. The register starts at all ones. Each byte is processed bit 0 first: feedback = reg[0] XOR bit, reg is shifted right by one, and if the feedback is set the register is XORed with 32'hEDB88320. There is no final inversion. `dec_hash_hit` = `dec_mcast` AND `hash_table[index]`.
- R6: Policy 00 accepts only when `dec_own_hit` is set.
- R7: Policy 01 accepts when the station matches, the frame is broadcast, or `dec_hash_hit` is set.
- R8: Policy 10 accepts when the station matches, the frame is broadcast, or the frame is multicast.
- R9: Policy 11 accepts every frame.
- R10: One cycle after `rx_frame_end`, `status_valid` pulses and `status_word` holds the following fields:
  - bits 15:0: `rx_len`
  - bit 16: code violation
  - bit 17: dribble nibble
  - bit 18: CRC error
  - bit 19: multicast
  - bit 20: broadcast
  - bit 21: invalid preamble
  - bit 22: long event
  - bit 23: bad packet
  - bit 24: carrier event
  - bit 25: hash hit
  - bit 26: station hit
  - bit 63: one
  - all other bits: zero

  The word holds its value between pulses. `rx_err_flags` bits 0..6 are, in order: code violation, dribble, CRC error, invalid preamble, long event, bad packet, carrier event.
- R11: `status_err`, registered with the word, is the OR of code violation, CRC error, invalid preamble, long event, bad packet and carrier event. Dribble is excluded.
- R12: When the decision is made with `rx_dma_en` high, `hash_sel_latched` takes the selected raw table bit. Otherwise it holds its value.
- R13: A frame start clears all match flags and `dec_accept`. A frame ending before six bytes therefore reports zero match bits. When a frame end coincides with the next frame start, the status word carries the flags of the ending frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| filt_mode | input | 2 | Acceptance policy |
| own_addr | input | 48 | Station address, first byte in bits 7:0 |
| hash_table | input | 64 | Multicast hash table |
| rx_dma_en | input | 1 | Receive DMA enabled, gates the hash latch |
| rx_byte_valid | input | 1 | Byte strobe |
| rx_frame_start | input | 1 | First byte of a frame |
| rx_byte | input | 8 | Received byte |
| rx_frame_end | input | 1 | End-of-frame strobe |
| rx_len | input | 16 | Received length, valid with frame end |
| rx_err_flags | input | 7 | MAC error flags, valid with frame end |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | Frame accepted |
| dec_own_hit | output | 1 | Station address match |
| dec_bcast | output | 1 | Broadcast address |
| dec_mcast | output | 1 | Multicast address |
| dec_hash_hit | output | 1 | Multicast hash hit |
| hash_sel_latched | output | 1 | Latched raw hash table bit |
| status_valid | output | 1 | Status word pulse |
| status_word | output | 64 | Packed receive status |
| status_err | output | 1 | Aggregate receive error |

## Verification
The status packer and the address classifier can act in the same cycle. This happens when one frame's end strobe arrives together with the first byte of the next frame, which also clears the match flags. The bench provokes this with back-to-back frames whose match flags differ. It checks that the packed word reports the ending frame while the flags reset for the new one. A behavioural model, built on queues of bytes and a bit-serial CRC, predicts every output on every clock. Runt frames, byte gaps, trailing bytes and hash lookups with DMA disabled are also covered.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   typedef enum logic [1:0] {
      FILT_OWN   = 2'b00,
      FILT_HASH  = 2'b01,
      FILT_ALLMC = 2'b10,
      FILT_ALL   = 2'b11
   } filt_mode_e;

   // status word bit positions (decoded downstream)
   localparam int SW_WIDTH     = 64;
   localparam int SW_CODE_VIOL = 16;
   localparam int SW_DRIBBLE   = 17;
   localparam int SW_CRC_ERR   = 18;
   localparam int SW_MCAST     = 19;
   localparam int SW_BCAST     = 20;
   localparam int SW_BAD_PRE   = 21;
   localparam int SW_LONG      = 22;
   localparam int SW_BAD_PKT   = 23;
   localparam int SW_CARRIER   = 24;
   localparam int SW_HASH_HIT  = 25;
   localparam int SW_OWN_HIT   = 26;
   localparam int SW_VALID     = 63;

   // error flag input positions
   localparam int EF_W         = 7;
   localparam int EF_CODE_VIOL = 0;
   localparam int EF_DRIBBLE   = 1;
   localparam int EF_CRC_ERR   = 2;
   localparam int EF_BAD_PRE   = 3;
   localparam int EF_LONG      = 4;
   localparam int EF_BAD_PKT   = 5;
   localparam int EF_CARRIER   = 6;

   localparam int          CRC_W    = 32;
   localparam logic [31:0] CRC_POLY = 32'hEDB88320;

   function automatic logic [CRC_W-1:0] crc_step_byte(input logic [CRC_W-1:0] c,
                                                      input logic [7:0] d);
      logic [CRC_W-1:0] r;
      r = c;
      for (int i = 0; i < 8; i++) begin
         if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
         else             r = r >> 1;
      end
      return r;
   endfunction

endpackage

// File: rtl/rxf_addr_capture.sv
module rxf_addr_capture
   import rxf_pkg::*;
#(
   parameter int ADDR_BYTES = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    byte_valid,
   input  logic                    frame_start,
   input  logic [7:0]              byte_data,
   output logic [8*ADDR_BYTES-1:0] addr_now,
   output logic [CRC_W-1:0]        crc_now,
   output logic                    addr_done
);
   localparam int             CNT_W    = $clog2(ADDR_BYTES + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ADDR_BYTES);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_BYTES - 1);

   if (ADDR_BYTES < 1) begin : g_bad_bytes
      $error("rxf_addr_capture: ADDR_BYTES must be at least 1");
   end

   logic [CNT_W-1:0]           cnt_q;
   logic [CNT_W-1:0]           pos;
   logic [ADDR_BYTES-1:0][7:0] addr_q;
   logic [CRC_W-1:0]           crc_q;
   logic [CRC_W-1:0]           crc_base;
   logic                       take;

   always_comb begin
      pos       = frame_start ? '0 : cnt_q;
      take      = byte_valid & (frame_start | (cnt_q < CNT_FULL));
      crc_base  = frame_start ? '1 : crc_q;
      crc_now   = crc_step_byte(crc_base, byte_data);
      addr_done = take & (pos == CNT_LAST);
   end

   for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_slot
      logic hit;
      assign hit = take && (pos == CNT_W'(k));
      assign addr_now[8*k +: 8] = hit ? byte_data : addr_q[k];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   addr_q[k] <= '0;
         else if (hit) addr_q[k] <= byte_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CNT_FULL;
         crc_q <= '1;
      end else if (take) begin
         cnt_q <= pos + 1'b1;
         crc_q <= crc_now;
      end
   end

   // R2: the byte counter never runs past the address length
   assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_FULL);

endmodule

// File: rtl/rxf_classify.sv
module rxf_classify
   import rxf_pkg::*;
#(
   parameter int ADDR_BYTES = 6,
   parameter int HASH_BITS  = 6,
   parameter bit HASH_EN    = 1'b1
) (
   input  logic [8*ADDR_BYTES-1:0]  addr,
   input  logic [CRC_W-1:0]         crc,
   input  logic [8*ADDR_BYTES-1:0]  own_addr,
   input  logic [(1<<HASH_BITS)-1:0] hash_table,
   input  logic [1:0]               mode,
   output logic                     own_hit,
   output logic                     bcast,
   output logic                     mcast,
   output logic                     tbl_bit,
   output logic                     hash_hit,
   output logic                     accept
);
   if (HASH_BITS < 1 || HASH_BITS > CRC_W) begin : g_bad_hash
      $error("rxf_classify: HASH_BITS out of range");
   end

   logic [ADDR_BYTES-1:0] byte_eq;
   logic [HASH_BITS-1:0]  idx;

   for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_cmp
      assign byte_eq[k] = (addr[8*k +: 8] == own_addr[8*k +: 8]);
   end

   assign own_hit = &byte_eq;
   assign bcast   = &addr;
   assign mcast   = addr[0] & ~bcast;
   assign idx     = crc[CRC_W-1 -: HASH_BITS];
   assign tbl_bit = hash_table[idx];

   if (HASH_EN) begin : g_hash
      assign hash_hit = mcast & tbl_bit;
   end else begin : g_nohash
      assign hash_hit = 1'b0;
   end

   always_comb begin
      unique case (filt_mode_e'(mode))
         FILT_OWN:   accept = own_hit;
         FILT_HASH:  accept = own_hit | bcast | hash_hit;
         FILT_ALLMC: accept = own_hit | bcast | mcast;
         default:    accept = 1'b1;
      endcase
   end

endmodule

// File: rtl/rxf_status_pack.sv
module rxf_status_pack
   import rxf_pkg::*;
#(
   parameter int LEN_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                frame_end,
   input  logic [LEN_W-1:0]    len,
   input  logic [EF_W-1:0]     err,
   input  logic                own_hit,
   input  logic                bcast,
   input  logic                mcast,
   input  logic                hash_hit,
   output logic                status_valid,
   output logic [SW_WIDTH-1:0] status_word,
   output logic                status_err
);
   if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
      $error("rxf_status_pack: LEN_W must be 1..16");
   end

   logic [SW_WIDTH-1:0] word_d;
   logic                err_d;

   always_comb begin
      word_d               = '0;
      word_d[LEN_W-1:0]    = len;
      word_d[SW_CODE_VIOL] = err[EF_CODE_VIOL];
      word_d[SW_DRIBBLE]   = err[EF_DRIBBLE];
      word_d[SW_CRC_ERR]   = err[EF_CRC_ERR];
      word_d[SW_MCAST]     = mcast;
      word_d[SW_BCAST]     = bcast;
      word_d[SW_BAD_PRE]   = err[EF_BAD_PRE];
      word_d[SW_LONG]      = err[EF_LONG];
      word_d[SW_BAD_PKT]   = err[EF_BAD_PKT];
      word_d[SW_CARRIER]   = err[EF_CARRIER];
      word_d[SW_HASH_HIT]  = hash_hit;
      word_d[SW_OWN_HIT]   = own_hit;
      word_d[SW_VALID]     = 1'b1;
      err_d = err[EF_CODE_VIOL] | err[EF_CRC_ERR] | err[EF_BAD_PRE] |
              err[EF_LONG] | err[EF_BAD_PKT] | err[EF_CARRIER];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_valid <= 1'b0;
         status_word  <= '0;
         status_err   <= 1'b0;
      end else begin
         status_valid <= frame_end;
         if (frame_end) begin
            status_word <= word_d;
            status_err  <= err_d;
         end
      end
   end

   assert_word_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      status_valid |-> status_word[SW_VALID]);
   assert_word_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(frame_end) |-> $stable(status_word));
   assert_err_sum_R11: assert property (@(posedge clk) disable iff (!rst_n)
      status_valid |-> (status_err == (status_word[SW_CODE_VIOL] | status_word[SW_CRC_ERR] |
                        status_word[SW_BAD_PRE] | status_word[SW_LONG] |
                        status_word[SW_BAD_PKT] | status_word[SW_CARRIER])));

endmodule

// File: rtl/rxf_daddr_filter.sv
module rxf_daddr_filter
   import rxf_pkg::*;
#(
   parameter int ADDR_BYTES = 6,
   parameter int HASH_BITS  = 6,
   parameter int LEN_W      = 16,
   parameter bit HASH_EN    = 1'b1,
   localparam int ADDR_W    = 8 * ADDR_BYTES,
   localparam int TABLE_W   = 1 << HASH_BITS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          filt_mode,
   input  logic [ADDR_W-1:0]   own_addr,
   input  logic [TABLE_W-1:0]  hash_table,
   input  logic                rx_dma_en,
   input  logic                rx_byte_valid,
   input  logic                rx_frame_start,
   input  logic [7:0]          rx_byte,
   input  logic                rx_frame_end,
   input  logic [LEN_W-1:0]    rx_len,
   input  logic [EF_W-1:0]     rx_err_flags,
   output logic                dec_valid,
   output logic                dec_accept,
   output logic                dec_own_hit,
   output logic                dec_bcast,
   output logic                dec_mcast,
   output logic                dec_hash_hit,
   output logic                hash_sel_latched,
   output logic                status_valid,
   output logic [SW_WIDTH-1:0] status_word,
   output logic                status_err
);
   logic [ADDR_W-1:0] addr_now;
   logic [CRC_W-1:0]  crc_now;
   logic              addr_done;
   logic              c_own, c_bc, c_mc, c_tbl, c_hh, c_acc;
   logic              new_frame;

   assign new_frame = rx_byte_valid & rx_frame_start;

   rxf_addr_capture #(.ADDR_BYTES(ADDR_BYTES)) u_capture (
      .clk         (clk),
      .rst_n       (rst_n),
      .byte_valid  (rx_byte_valid),
      .frame_start (rx_frame_start),
      .byte_data   (rx_byte),
      .addr_now    (addr_now),
      .crc_now     (crc_now),
      .addr_done   (addr_done)
   );

   rxf_classify #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS), .HASH_EN(HASH_EN)) u_classify (
      .addr       (addr_now),
      .crc        (crc_now),
      .own_addr   (own_addr),
      .hash_table (hash_table),
      .mode       (filt_mode),
      .own_hit    (c_own),
      .bcast      (c_bc),
      .mcast      (c_mc),
      .tbl_bit    (c_tbl),
      .hash_hit   (c_hh),
      .accept     (c_acc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid        <= 1'b0;
         dec_accept       <= 1'b0;
         dec_own_hit      <= 1'b0;
         dec_bcast        <= 1'b0;
         dec_mcast        <= 1'b0;
         dec_hash_hit     <= 1'b0;
         hash_sel_latched <= 1'b0;
      end else begin
         dec_valid <= addr_done;
         if (addr_done) begin
            dec_accept   <= c_acc;
            dec_own_hit  <= c_own;
            dec_bcast    <= c_bc;
            dec_mcast    <= c_mc;
            dec_hash_hit <= c_hh;
            if (rx_dma_en) hash_sel_latched <= c_tbl;
         end else if (new_frame) begin
            dec_accept   <= 1'b0;
            dec_own_hit  <= 1'b0;
            dec_bcast    <= 1'b0;
            dec_mcast    <= 1'b0;
            dec_hash_hit <= 1'b0;
         end
      end
   end

   rxf_status_pack #(.LEN_W(LEN_W)) u_status (
      .clk          (clk),
      .rst_n        (rst_n),
      .frame_end    (rx_frame_end),
      .len          (rx_len),
      .err          (rx_err_flags),
      .own_hit      (dec_own_hit),
      .bcast        (dec_bcast),
      .mcast        (dec_mcast),
      .hash_hit     (dec_hash_hit),
      .status_valid (status_valid),
      .status_word  (status_word),
      .status_err   (status_err)
   );

   assert_dec_after_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> $past(rx_byte_valid));
   assert_dec_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |=> !dec_valid || $past(rx_byte_valid));
   assert_cast_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(dec_bcast && dec_mcast));
   assert_hash_mc_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dec_hash_hit |-> dec_mcast);
   assert_own_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && $past(filt_mode) == 2'b00 && dec_accept) |-> dec_own_hit);
   assert_hash_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && $past(filt_mode) == 2'b01 && dec_accept) |->
      (dec_own_hit || dec_bcast || dec_hash_hit));
   assert_allmc_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && $past(filt_mode) == 2'b10 && dec_mcast) |-> dec_accept);
   assert_promisc_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && $past(filt_mode) == 2'b11) |-> dec_accept);
   assert_latch_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rx_dma_en) |-> $stable(hash_sel_latched));
   assert_start_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rx_byte_valid && rx_frame_start) && !dec_valid) |->
      !(dec_accept || dec_own_hit || dec_bcast || dec_mcast));

endmodule

// File: tb/test_rxf_daddr_filter.sv
`timescale 1ns/1ps
module test_rxf_daddr_filter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  filt_mode = 2'b00;
   logic [47:0] own_addr = 48'h55_44_33_22_11_00;
   logic [63:0] hash_table = '0;
   logic        rx_dma_en = 1'b1;
   logic        rx_byte_valid = 1'b0, rx_frame_start = 1'b0, rx_frame_end = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic [15:0] rx_len = '0;
   logic [6:0]  rx_err_flags = '0;
   logic        dec_valid, dec_accept, dec_own_hit, dec_bcast, dec_mcast, dec_hash_hit;
   logic        hash_sel_latched, status_valid, status_err;
   logic [63:0] status_word;

   always #4 clk = ~clk;

   rxf_daddr_filter i_rxf_daddr_filter (
      .clk(clk), .rst_n(rst_n), .filt_mode(filt_mode), .own_addr(own_addr),
      .hash_table(hash_table), .rx_dma_en(rx_dma_en), .rx_byte_valid(rx_byte_valid),
      .rx_frame_start(rx_frame_start), .rx_byte(rx_byte), .rx_frame_end(rx_frame_end),
      .rx_len(rx_len), .rx_err_flags(rx_err_flags), .dec_valid(dec_valid),
      .dec_accept(dec_accept), .dec_own_hit(dec_own_hit), .dec_bcast(dec_bcast),
      .dec_mcast(dec_mcast), .dec_hash_hit(dec_hash_hit),
      .hash_sel_latched(hash_sel_latched), .status_valid(status_valid),
      .status_word(status_word), .status_err(status_err));

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   function automatic logic [31:0] crc_step(logic [31:0] c, logic [7:0] d);
      for (int i = 0; i < 8; i++) begin
         logic fb;
         fb = c[0] ^ d[i];
         c  = c >> 1;
         if (fb) c = c ^ 32'hEDB88320;
      end
      return c;
   endfunction

   function automatic int hidx(logic [47:0] a);
      logic [31:0] c;
      c = '1;
      for (int k = 0; k < 6; k++) c = crc_step(c, a[8*k +: 8]);
      return int'(c[31:26]);
   endfunction

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
      end
   endtask

   // reference model
   int          m_cnt;
   logic [7:0]  m_q[$];
   logic [31:0] m_crc;
   logic        e_dv, e_acc, e_own, e_bc, e_mc, e_hh, e_hl, e_sv, e_se;
   logic [63:0] e_sw;
   logic [1:0]  e_mode;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 6; m_q.delete(); m_crc = '1;
         e_dv = 0; e_acc = 0; e_own = 0; e_bc = 0; e_mc = 0; e_hh = 0; e_hl = 0;
         e_sv = 0; e_se = 0; e_sw = '0; e_mode = 2'b00;
      end else begin
         e_sv = rx_frame_end;
         if (rx_frame_end) begin
            e_sw = '0;
            e_sw[63] = 1'b1;
            e_sw[15:0] = rx_len;
            e_sw[16] = rx_err_flags[0];
            e_sw[17] = rx_err_flags[1];
            e_sw[18] = rx_err_flags[2];
            e_sw[21] = rx_err_flags[3];
            e_sw[22] = rx_err_flags[4];
            e_sw[23] = rx_err_flags[5];
            e_sw[24] = rx_err_flags[6];
            e_sw[19] = e_mc; e_sw[20] = e_bc; e_sw[25] = e_hh; e_sw[26] = e_own;
            e_se = rx_err_flags[0] | rx_err_flags[2] | rx_err_flags[3] |
                   rx_err_flags[4] | rx_err_flags[5] | rx_err_flags[6];
         end
         e_dv = 1'b0;
         if (rx_byte_valid) begin
            if (rx_frame_start) begin
               m_cnt = 0; m_q.delete(); m_crc = '1;
               e_acc = 0; e_own = 0; e_bc = 0; e_mc = 0; e_hh = 0;
            end
            if (m_cnt < 6) begin
               logic [47:0] full;
               logic        tb;
               m_q.push_back(rx_byte);
               m_crc = crc_step(m_crc, rx_byte);
               m_cnt++;
               if (m_cnt == 6) begin
                  for (int k = 0; k < 6; k++) full[8*k +: 8] = m_q[k];
                  tb    = hash_table[m_crc[31:26]];
                  e_own = (full == own_addr);
                  e_bc  = &full;
                  e_mc  = full[0] && !e_bc;
                  e_hh  = e_mc && tb;
                  e_mode = filt_mode;
                  case (filt_mode)
                     2'b00:   e_acc = e_own;
                     2'b01:   e_acc = e_own || e_bc || e_hh;
                     2'b10:   e_acc = e_own || e_bc || e_mc;
                     default: e_acc = 1'b1;
                  endcase
                  e_dv = 1'b1;
                  if (rx_dma_en) e_hl = tb;
               end
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         string acc_tag;
         case (e_mode)
            2'b00:   acc_tag = "R6 accept";
            2'b01:   acc_tag = "R7 accept";
            2'b10:   acc_tag = "R8 accept";
            default: acc_tag = "R9 accept";
         endcase
         chk("R2 dec_valid", 64'(dec_valid), 64'(e_dv));
         chk(acc_tag, 64'(dec_accept), 64'(e_acc));
         chk("R4 own_hit", 64'(dec_own_hit), 64'(e_own));
         chk("R3 bcast", 64'(dec_bcast), 64'(e_bc));
         chk("R3 mcast", 64'(dec_mcast), 64'(e_mc));
         chk("R5 hash_hit", 64'(dec_hash_hit), 64'(e_hh));
         chk("R12 hash latch", 64'(hash_sel_latched), 64'(e_hl));
         chk("R10 status_valid", 64'(status_valid), 64'(e_sv));
         chk("R10 R13 status_word", status_word, e_sw);
         chk("R11 status_err", 64'(status_err), 64'(e_se));
      end
   end

   task automatic idle(int n);
      repeat (n) begin
         @(negedge clk);
         rx_byte_valid = 0; rx_frame_start = 0; rx_frame_end = 0;
      end
   endtask

   task automatic put(logic [7:0] b, bit first, bit fend);
      @(negedge clk);
      rx_byte_valid = 1; rx_frame_start = first; rx_byte = b; rx_frame_end = fend;
   endtask

   task automatic fend(logic [15:0] len, logic [6:0] flags);
      @(negedge clk);
      rx_byte_valid = 0; rx_frame_start = 0; rx_frame_end = 1;
      rx_len = len; rx_err_flags = flags;
   endtask

   task automatic frame(logic [47:0] da, int extra, int gap, logic [15:0] len, logic [6:0] flags);
      for (int k = 0; k < 6 + extra; k++) begin
         put((k < 6) ? da[8*k +: 8] : 8'(k * 37), k == 0, 1'b0);
         if (gap > 0 && k == 2) idle(gap);
      end
      fend(len, flags);
      idle(2);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   localparam logic [47:0] UNI2 = 48'h0A_0B_0C_0D_0E_02;
   localparam logic [47:0] MC1  = 48'h12_34_5E_00_00_01;
   localparam logic [47:0] MC2  = 48'hAB_00_00_00_33_01;
   localparam logic [47:0] BC   = 48'hFF_FF_FF_FF_FF_FF;

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 reset outputs",
          {dec_valid, dec_accept, dec_own_hit, dec_bcast, dec_mcast, dec_hash_hit,
           hash_sel_latched, status_valid, status_err} != 0 ? 64'd1 : 64'd0, 64'd0);
      chk("R1 reset word", status_word, 64'd0);
      rst_n = 1;
      // bytes before any frame start are ignored (R2)
      put(8'h00, 0, 0); put(8'h11, 0, 0); idle(2);
      // R6 policy 00
      filt_mode = 2'b00;
      frame(own_addr, 3, 0, 16'd64, 7'h00);
      frame(UNI2, 0, 2, 16'd70, 7'h01);
      frame(BC, 0, 0, 16'd60, 7'h02);
      frame(MC1, 1, 0, 16'd99, 7'h04);
      // R7 policy 01 with hash
      filt_mode = 2'b01;
      hash_table = 64'd1 << hidx(MC1);
      frame(MC1, 0, 0, 16'd128, 7'h08);
      frame(MC2, 0, 1, 16'd129, 7'h10);
      hash_table = ~(64'd1 << hidx(MC1));
      frame(MC1, 0, 0, 16'd130, 7'h20);
      frame(BC, 0, 0, 16'd131, 7'h40);
      frame(UNI2, 0, 0, 16'd132, 7'h7F);
      frame(own_addr, 0, 0, 16'd133, 7'h00);
      // R8 policy 10
      filt_mode = 2'b10;
      hash_table = '0;
      frame(MC1, 0, 0, 16'd200, 7'h00);
      frame(UNI2, 0, 0, 16'd201, 7'h00);
      frame(BC, 0, 0, 16'd202, 7'h00);
      // R9 policy 11
      filt_mode = 2'b11;
      frame(UNI2, 0, 0, 16'd300, 7'h00);
      frame(MC2, 2, 3, 16'd301, 7'h00);
      // R12: DMA off keeps latch
      filt_mode = 2'b01;
      hash_table = '1;
      frame(MC2, 0, 0, 16'd400, 7'h00);
      rx_dma_en = 0;
      hash_table = '0;
      frame(MC2, 0, 0, 16'd401, 7'h00);
      rx_dma_en = 1;
      frame(MC2, 0, 0, 16'd402, 7'h00);
      // R13: runt frame after an accepted one
      hash_table = '1;
      frame(MC1, 0, 0, 16'd500, 7'h00);
      put(own_addr[7:0], 1, 0); put(own_addr[15:8], 0, 0); put(own_addr[23:16], 0, 0);
      fend(16'd3, 7'h04);
      idle(2);
      // R13: end of one frame together with start of the next
      filt_mode = 2'b00;
      for (int k = 0; k < 6; k++) put(own_addr[8*k +: 8], k == 0, 1'b0);
      @(negedge clk);
      rx_byte_valid = 1; rx_frame_start = 1; rx_byte = BC[7:0];
      rx_frame_end = 1; rx_len = 16'd600; rx_err_flags = 7'h02;
      for (int k = 1; k < 6; k++) put(BC[8*k +: 8], 1'b0, 1'b0);
      @(negedge clk);
      rx_byte_valid = 1; rx_frame_start = 1; rx_byte = UNI2[7:0];
      rx_frame_end = 1; rx_len = 16'd601; rx_err_flags = 7'h00;
      for (int k = 1; k < 6; k++) put(UNI2[8*k +: 8], 1'b0, 1'b0);
      fend(16'd602, 7'h00);
      idle(4);
      done = 1;
      summary();
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual=hung expected=finished");
         summary();
         $finish;
      end
   end

endmodule